// File: doc/BRIEF.md
# Two-Stage SPI Serial Clock Generator

This block turns a fast main clock into the serial clock of an SPI master. A first stage divides the main clock by a power of two picked by a 2-bit prescale code. A second stage counts prescaler ticks to form each serial-clock half-period, with the half-period length picked by a 6-bit rate code. A full serial-clock period is therefore `2 * (rate + 1) * (2 << prescale)` main-clock cycles. The fastest setting gives one twentieth of the main clock and the slowest gives one part in 2048.

The shift engine next to this block does not watch the clock pin itself. It uses two one-cycle strobes instead: one marks the move of the serial clock away from its idle level, and the other marks its return. While the enable is low, the serial clock rests at the idle level chosen by the polarity input, both counters stay at zero, and the configuration inputs are sampled. While the enable is high, the sampled configuration is frozen. The rate code is raised to its legal floor of 4 when it is sampled.

Top module: `spi_sck_gen`

## Requirements
- R1: While reset is asserted (rst_n low at a clock edge), sck, lead_stb and trail_stb are all 0 from the following cycle onward.
- R2: After any clock edge at which en is 0, sck equals the cpol value sampled at that edge, and neither strobe is set.
- R3: The prescaler divides by 2, 4, 8 or 16 for prescale codes 0, 1, 2 and 3 (ratio = 2 << code).
- R4: With en held at 1 from edge 1, sck first changes after edge H, where H = (rate + 1) * (2 << prescale). It changes again after every further H edges.
- R5: A rate code of 0 to 3 behaves exactly like a rate code of 4. Codes 4 to 63 are used as given.
- R6: Out of reset, the frozen configuration is rate 4 and prescale 0. If en is already high when reset releases, sck toggles every 10 cycles, whatever the configuration inputs hold.
- R7: lead_stb is high for exactly the cycle in which sck first shows its non-idle level, and trail_stb for exactly the cycle in which sck shows its return to idle. The two are never high together.
- R8: Changes to the prescale code, the rate code or cpol made while en is high do not change the serial clock timing.
- R9: Each rise of en restarts both counters, so the first half-period after re-enabling has full length H, even if the previous run stopped in the middle of a half-period.
- R10: With cpol = 1 the idle level is high, the leading edge is a fall and the trailing edge is a rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run the divider. Low means idle and sample the configuration |
| div_sel | input | 2 | Prescale code; ratio is 2 << code |
| brg_val | input | 6 | Half-period count code, raised to 4 if smaller |
| cpol | input | 1 | Idle level of the serial clock |
| sck | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe aligned with the leaving-idle transition |
| trail_stb | output | 1 | One-cycle strobe aligned with the return-to-idle transition |

## Verification
Every output is registered. A change caused at clock edge n is therefore seen in the cycle after that edge. The bench drives inputs and samples outputs at falling edges, and numbers the rising edges from the first one at which en is seen high. The expected serial-clock level and both strobes are computed for every cycle of a run from H alone: the level toggles at each multiple of H, and the strobe kind alternates with the parity of that multiple. Idle behaviour is checked one edge after en falls. Configuration changes made mid-run are checked by keeping the expectation from the configuration sampled before enable.

// File: rtl/spi_sck_pkg.sv
// Shared defaults and types for the serial clock generator.
package spi_sck_pkg;
    localparam int SCK_DIV_W     = 2;  // prescale code width
    localparam int SCK_BRG_W     = 6;  // half-period code width
    localparam int SCK_BRG_FLOOR = 4;  // smallest legal half-period code
    localparam int SCK_BRG_RST   = 4;  // code used out of reset
    localparam int SCK_DIV_RST   = 0;  // prescale code used out of reset

    // Kind of serial clock transition produced in a cycle
    typedef enum logic [1:0] {
        SCK_EDGE_NONE  = 2'd0,
        SCK_EDGE_LEAD  = 2'd1,
        SCK_EDGE_TRAIL = 2'd2
    } sck_edge_e;
endpackage

// File: rtl/sck_cfg_hold.sv
// Configuration holder: samples the prescale code, half-period code and
// polarity every cycle while load is high, raising the half-period code to
// its floor. Assumes load is the inverse of the run enable, so the values
// are frozen for as long as the divider runs.
module sck_cfg_hold #(
    parameter int DIV_W     = 2,
    parameter int BRG_W     = 6,
    parameter int BRG_FLOOR = 4,
    parameter int BRG_RST   = 4,
    parameter int DIV_RST   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    input  logic [BRG_W-1:0] brg_in,
    input  logic             cpol_in,
    output logic [DIV_W-1:0] div_q,
    output logic [BRG_W-1:0] brg_q,
    output logic             cpol_q
);
    localparam logic [BRG_W-1:0] FLOOR_V = BRG_W'(BRG_FLOOR);

    logic [BRG_W-1:0] brg_legal;

    // Raise an illegal small half-period code to the floor
    always_comb begin
        brg_legal = (brg_in < FLOOR_V) ? FLOOR_V : brg_in;
    end

    // Capture configuration while idle; hold it while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= DIV_W'(DIV_RST);
            brg_q  <= BRG_W'(BRG_RST);
            cpol_q <= 1'b0;
        end else if (load) begin
            div_q  <= div_in;
            brg_q  <= brg_legal;
            cpol_q <= cpol_in;
        end
    end
endmodule

// File: rtl/sck_prescale.sv
// Power-of-two prescaler: while run is high, emits a one-cycle tick every
// (2 << div) main-clock cycles. The counter sits at zero while run is low,
// so the first tick after run rises comes a full ratio later.
module sck_prescale #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = (1 << DIV_W);   // wide enough for the largest ratio

    logic [CNT_W:0]   ratio;
    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] cnt;

    // Terminal count for the selected ratio
    always_comb begin
        ratio = (CNT_W+1)'(2) << div;
        last  = CNT_W'(ratio - (CNT_W+1)'(1));
    end

    assign tick = run && (cnt == last);

    // Count main-clock cycles, wrapping at the terminal count
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/sck_halfper.sv
// Half-period stage: counts prescaler ticks and toggles the serial clock
// after (brg + 1) of them. Both strobes are registered in the same edge as
// the clock level, so they line up with the transition. Idle level follows
// cpol_idle while run is low; run_pol is the frozen polarity used to
// tell leading from trailing transitions.
module sck_halfper #(
    parameter int BRG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [BRG_W-1:0] brg,
    input  logic             cpol_idle,
    input  logic             run_pol,
    output logic             sck,
    output logic             lead_stb,
    output logic             trail_stb
);
    import spi_sck_pkg::*;

    logic [BRG_W-1:0] hp_cnt;
    logic             flip;
    sck_edge_e        edge_kind;

    // A transition is due on the tick that completes the half-period
    always_comb begin
        flip = tick && (hp_cnt == brg);
        if (!flip)
            edge_kind = SCK_EDGE_NONE;
        else if (sck == run_pol)
            edge_kind = SCK_EDGE_LEAD;
        else
            edge_kind = SCK_EDGE_TRAIL;
    end

    // Tick counter within the current half-period
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            hp_cnt <= '0;
        end else if (flip) begin
            hp_cnt <= '0;
        end else if (tick) begin
            hp_cnt <= hp_cnt + BRG_W'(1);
        end
    end

    // Serial clock level and the aligned transition strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck       <= 1'b0;
            lead_stb  <= 1'b0;
            trail_stb <= 1'b0;
        end else if (!run) begin
            sck       <= cpol_idle;
            lead_stb  <= 1'b0;
            trail_stb <= 1'b0;
        end else begin
            sck       <= flip ? ~sck : sck;
            lead_stb  <= (edge_kind == SCK_EDGE_LEAD);
            trail_stb <= (edge_kind == SCK_EDGE_TRAIL);
        end
    end
endmodule

// File: rtl/spi_sck_gen.sv
// Top of the serial clock generator: configuration holder, power-of-two
// prescaler and half-period stage. Assumes en, div_sel, brg_val and cpol
// are synchronous to clk; the configuration is frozen while en is high.
module spi_sck_gen #(
    parameter int DIV_W     = spi_sck_pkg::SCK_DIV_W,
    parameter int BRG_W     = spi_sck_pkg::SCK_BRG_W,
    parameter int BRG_FLOOR = spi_sck_pkg::SCK_BRG_FLOOR,
    parameter int BRG_RST   = spi_sck_pkg::SCK_BRG_RST,
    parameter int DIV_RST   = spi_sck_pkg::SCK_DIV_RST
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [BRG_W-1:0] brg_val,
    input  logic             cpol,
    output logic             sck,
    output logic             lead_stb,
    output logic             trail_stb
);
    logic [DIV_W-1:0] div_q;
    logic [BRG_W-1:0] brg_q;
    logic             cpol_q;
    logic             tick;

    sck_cfg_hold #(
        .DIV_W(DIV_W), .BRG_W(BRG_W), .BRG_FLOOR(BRG_FLOOR),
        .BRG_RST(BRG_RST), .DIV_RST(DIV_RST)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(!en),
        .div_in(div_sel), .brg_in(brg_val), .cpol_in(cpol),
        .div_q(div_q), .brg_q(brg_q), .cpol_q(cpol_q)
    );

    sck_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(en), .div(div_q), .tick(tick)
    );

    sck_halfper #(.BRG_W(BRG_W)) u_hp (
        .clk(clk), .rst_n(rst_n), .run(en), .tick(tick), .brg(brg_q),
        .cpol_idle(cpol), .run_pol(cpol_q),
        .sck(sck), .lead_stb(lead_stb), .trail_stb(trail_stb)
    );
endmodule

// File: rtl/spi_sck_gen_chk.sv
// Property checker for the serial clock generator, bound to every instance.
module spi_sck_gen_chk #(
    parameter int MAX_HALF = 1024
) (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic cpol,
    input logic sck,
    input logic lead_stb,
    input logic trail_stb
);
    logic        sck_prev;
    logic [15:0] run_len;

    // Cycles since the last serial clock change during an enabled run
    always_ff @(posedge clk) begin
        if (!rst_n || !en || (sck != sck_prev)) begin
            run_len <= '0;
        end else begin
            run_len <= run_len + 16'd1;
        end
        sck_prev <= sck;
    end

    a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_stb && trail_stb));

    a_r7_strobe_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_stb || trail_stb) |-> (sck != $past(sck)));

    a_r7_change_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ((sck != $past(sck)) && $past(en)) |-> (lead_stb || trail_stb));

    a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ((sck == $past(cpol)) && !lead_stb && !trail_stb));

    a_r4_half_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= 16'(MAX_HALF));
endmodule

bind spi_sck_gen spi_sck_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol),
    .sck(sck), .lead_stb(lead_stb), .trail_stb(trail_stb)
);

// File: tb/spi_sck_gen_tb.sv
module spi_sck_gen_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic [5:0] brg_val = 6'd4;
    logic       cpol = 1'b0;
    logic       sck, lead_stb, trail_stb;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_sck_gen u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .div_sel(div_sel),
        .brg_val(brg_val), .cpol(cpol),
        .sck(sck), .lead_stb(lead_stb), .trail_stb(trail_stb)
    );

    // Half-period length in main cycles, from the requirements
    function automatic int half_len(input int dv, input int bg);
        int eb;
        eb = (bg < 4) ? 4 : bg;
        return (eb + 1) * (2 << dv);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fails);
            $finish;
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Check ncyc enabled cycles against half length h; optionally disturb
    // the configuration inputs mid-run (R8)
    task automatic watch(input int ncyc, input int h, input logic pol,
                         input string tag, input bit disturb);
        for (int n = 1; n <= ncyc; n++) begin
            int q, r;
            step();
            q = n / h;
            r = n % h;
            check(tag, sck, pol ^ q[0]);
            check({tag, "/R7 lead"}, lead_stb, (r == 0) && q[0]);
            check({tag, "/R7 trail"}, trail_stb, (r == 0) && !q[0] && q > 0);
            if (disturb && n == h / 2) begin
                div_sel = ~div_sel;
                brg_val = brg_val ^ 6'h2a;
                cpol    = ~cpol;
            end
        end
    endtask

    // Configure while idle, run, then disable and check the idle level
    task automatic run_cfg(input int dv, input int bg, input logic pol,
                           input int ncyc, input string tag, input bit disturb);
        int h;
        h = half_len(dv, bg);
        en = 1'b0; div_sel = 2'(dv); brg_val = 6'(bg); cpol = pol;
        step();
        step();
        check("R2 idle sck", sck, pol);
        check("R2 idle strobes", lead_stb | trail_stb, 0);
        en = 1'b1;
        watch(ncyc, h, pol, tag, disturb);
        en = 1'b0; cpol = pol;
        step();
        check("R2 disable sck", sck, pol);
        check("R2 disable strobes", lead_stb | trail_stb, 0);
    endtask

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                n_fails++;
                n_checks++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        // R1: reset state, with en high and a slow configuration on the inputs
        en = 1'b1; div_sel = 2'd3; brg_val = 6'd63; cpol = 1'b0;
        step(); step(); step();
        check("R1 sck", sck, 0);
        check("R1 lead", lead_stb, 0);
        check("R1 trail", trail_stb, 0);
        // R6: release with en high; defaults give half length 10
        rst_n = 1'b1;
        watch(45, 10, 1'b0, "R6", 1'b0);
        en = 1'b0;
        step();

        // R3: each prescale ratio with the smallest rate code
        for (int d = 0; d < 4; d++) run_cfg(d, 4, 1'b0, 3 * half_len(d, 4), "R3", 1'b0);
        // R5: codes below the floor act as 4
        run_cfg(0, 0, 1'b0, 41, "R5", 1'b0);
        run_cfg(1, 3, 1'b0, 41, "R5", 1'b0);
        // R4: slowest setting
        run_cfg(3, 63, 1'b0, 2100, "R4 slowest", 1'b0);
        // R10: idle-high polarity
        run_cfg(1, 9, 1'b1, 3 * half_len(1, 9), "R10", 1'b0);
        // R8: inputs disturbed mid-run
        run_cfg(2, 7, 1'b0, 4 * half_len(2, 7), "R8", 1'b1);
        run_cfg(0, 20, 1'b1, 4 * half_len(0, 20), "R8", 1'b1);
        // R9: stop mid half-period, then restart with full length
        run_cfg(1, 5, 1'b0, half_len(1, 5) + 7, "R9 first", 1'b0);
        run_cfg(1, 5, 1'b0, 3 * half_len(1, 5), "R9 restart", 1'b0);
        // R4: random configurations
        for (int i = 0; i < 14; i++) begin
            int dv, bg, h;
            logic pol;
            dv  = int'($urandom_range(3, 0));
            bg  = int'($urandom_range(63, 0));
            pol = 1'($urandom_range(1, 0));
            h   = half_len(dv, bg);
            run_cfg(dv, bg, pol, (h > 300) ? h + 3 : 3 * h + 1, "R4 random", 1'($urandom_range(1, 0)));
        end
        finish_run();
    end
endmodule